// File: doc/BRIEF.md
# Single-Pin Serial Page-Write Decoder

This block is the device-side sequencer of a small nonvolatile memory that exchanges everything over one data pin, qualified by three active-low strobes (chip enable, output enable, write enable). It classifies each bus cycle as a write, a read or an unlock cycle. It then follows the order of those cycles to assemble a page write: an unlock, a 16-bit serial address, serial page data, and a read / write-one / read commit pattern.

Loaded bytes collect in a 32-byte page buffer, with a per-byte flag marking which entries were filled. A valid commit starts a programming interval of a set number of clock cycles. After that interval, the flagged bytes are copied into a register-array memory one per cycle. A read cycle during programming returns 0 on the data pin and returns 1 once the memory is ready.

A simplified read mode exists so the stored contents can be seen. After an unlock and an address, with no data bits loaded, read cycles stream the stored bits out. All pin inputs are taken to be synchronous to `clk`.

Top module: `spw_page_writer`

## Requirements
- R1: A cycle is a write when ce_n=0, we_n=0, oe_n=1; a read when ce_n=0, oe_n=0, we_n=1; an unlock when ce_n, oe_n and we_n are all 0. A cycle counts once, in the clock where its pin combination first appears. While ce_n=1 no cycle is seen and the sequence state does not change.
- R2: RST_CYCLES consecutive unlock cycles, with no read or write between them, set the write-enable latch and expect an address. Without the latch set, write cycles are ignored and no commit can start.
- R3: The address is exactly 16 write cycles, most significant bit first. A read among them aborts the sequence. An address with any bit at or above ADDR_BITS set also aborts it. Every abort clears the latch.
- R4: Data bits are shifted in most significant bit first, 8 per byte. The first byte goes to the byte position given by the low 5 address bits. The position wraps from 31 to 0 inside the 32-byte page, so a 33rd byte overwrites the first.
- R5: After one or more whole bytes, the pattern read, write of 1, read starts programming. Only page bytes loaded since the unlock are written to the memory.
- R6: A read that arrives with a partial byte loaded aborts the sequence. So does a write of 0, or a write in place of the final read, during the commit pattern. No memory write follows, and the latch is cleared.
- R7: A read during programming drives dio_out=0 with dio_oe=1. Outside programming and readback, a read returns 1. Unlock cycles and write cycles issued during programming change nothing.
- R8: Programming lasts PROG_CYCLES clocks, followed by one copy clock per page byte. After that the latch is clear and reads return 1.
- R9: After an unlock and an address, a read with no data loaded enters readback. Each read returns the next stored bit, most significant bit first, and the byte position wraps inside the page. A write cycle ends readback, and the following reads return 1.
- R10: After reset dio_oe=0, dio_out=0 and the latch is clear. dio_oe follows an active read combination one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| dio_in | input | 1 | Data pin value seen by the device |
| dio_out | output | 1 | Data pin value driven during reads |
| dio_oe | output | 1 | High while the device drives the data pin |

## Verification
The checker watches several rules on every clock. The sequence state holds still while chip enable is high. Programming begins only from the final commit read and only with the latch set. Reads during programming return 0. The memory is written only in the copy phase, and the latch is clear once the copy ends. Other behaviours can only be shown through the bench's scenarios, which read the stored bytes back through the pin. These cover the page wrap, the overwrite of the first byte by a 33rd, partial loads, a wrong commit bit, out-of-range addresses, and a write attempt without an unlock.

// File: rtl/spw_pkg.sv
package spw_pkg;

    localparam int SPW_ADDR_LEN = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_CMD1,
        ST_CMD2,
        ST_PROG,
        ST_COPY,
        ST_RDOUT
    } spw_state_e;

    typedef enum logic [1:0] {
        CY_NONE,
        CY_WR,
        CY_RD,
        CY_UNLK
    } spw_cyc_e;

endpackage

// File: rtl/spw_cycle_detect.sv
module spw_cycle_detect
    import spw_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ce_n,
    input  logic     oe_n,
    input  logic     we_n,
    output spw_cyc_e kind,
    output logic     ev
);

    spw_cyc_e kind_d, kind_q;

    always_comb begin
        if (ce_n)
            kind_d = CY_NONE;
        else if (!we_n && oe_n)
            kind_d = CY_WR;
        else if (!oe_n && we_n)
            kind_d = CY_RD;
        else if (!oe_n && !we_n)
            kind_d = CY_UNLK;
        else
            kind_d = CY_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            kind_q <= CY_NONE;
        else
            kind_q <= kind_d;
    end

    assign kind = kind_d;
    assign ev   = (kind_d != CY_NONE) && (kind_d != kind_q);

endmodule

// File: rtl/spw_page_buf.sv
module spw_page_buf #(
    parameter int PAGE_BYTES = 32,
    localparam int PW = $clog2(PAGE_BYTES)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [PW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] bytes_q [PAGE_BYTES];

    always_ff @(posedge clk) begin
        if (we)
            bytes_q[waddr] <= wdata;
    end

    assign rdata = bytes_q[raddr];

endmodule

// File: rtl/spw_array.sv
module spw_array #(
    parameter int ADDR_BITS = 11,
    localparam int DEPTH = 1 << ADDR_BITS
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [ADDR_BITS-1:0] waddr,
    input  logic [7:0]           wdata,
    input  logic [ADDR_BITS-1:0] raddr,
    output logic [7:0]           rdata
);

    logic [7:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            cells_q[waddr] <= wdata;
    end

    assign rdata = cells_q[raddr];

endmodule

// File: rtl/spw_page_writer.sv
module spw_page_writer
    import spw_pkg::*;
#(
    parameter int ADDR_BITS   = 11,
    parameter int PAGE_BYTES  = 32,
    parameter int PROG_CYCLES = 50,
    parameter int RST_CYCLES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic dio_in,
    output logic dio_out,
    output logic dio_oe
);

    localparam int PW = $clog2(PAGE_BYTES);
    localparam int CW = $clog2(PROG_CYCLES);
    localparam int RW = $clog2(RST_CYCLES + 1);
    localparam int AL = SPW_ADDR_LEN;

    typedef struct packed {
        spw_state_e          st;
        logic                wel;
        logic [AL-1:0]       ash;
        logic [3:0]          acnt;
        logic [ADDR_BITS-1:0] base;
        logic [PW-1:0]       ptr;
        logic [7:0]          bsh;
        logic [2:0]          bcnt;
        logic [PAGE_BYTES-1:0] mask;
        logic [CW-1:0]       pcnt;
        logic [PW-1:0]       cidx;
        logic [RW-1:0]       rcnt;
        logic                dio;
        logic                doe;
    } seq_t;

    seq_t q_d, q_q;

    spw_cyc_e kind;
    logic     ev;
    logic     rd_ev;
    logic     unlock_hit;
    logic     copy_last;
    logic     rd_bit;
    logic [AL-1:0] ash_nx;
    logic [7:0]    bsh_nx;

    logic          buf_we;
    logic [7:0]    buf_wdata;
    logic [7:0]    buf_rdata;
    logic          mem_we;
    logic [7:0]    mem_rdata;
    logic [ADDR_BITS-1:0] mem_waddr;
    logic [ADDR_BITS-1:0] mem_raddr;
    spw_state_e    st_q;

    spw_cycle_detect u_cyc (
        .clk   (clk),
        .rst_n (rst_n),
        .ce_n  (ce_n),
        .oe_n  (oe_n),
        .we_n  (we_n),
        .kind  (kind),
        .ev    (ev)
    );

    spw_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (q_q.ptr),
        .wdata (buf_wdata),
        .raddr (q_q.cidx),
        .rdata (buf_rdata)
    );

    spw_array #(.ADDR_BITS(ADDR_BITS)) u_arr (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (buf_rdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    assign mem_waddr = {q_q.base[ADDR_BITS-1:PW], q_q.cidx};
    assign mem_raddr = {q_q.base[ADDR_BITS-1:PW], q_q.ptr};
    assign rd_bit    = mem_rdata[3'd7 - q_q.bcnt];
    assign copy_last = (q_q.st == ST_COPY) && (q_q.cidx == PW'(PAGE_BYTES - 1));
    assign rd_ev     = ev && (kind == CY_RD);
    assign ash_nx    = {q_q.ash[AL-2:0], dio_in};
    assign bsh_nx    = {q_q.bsh[6:0], dio_in};
    assign st_q      = q_q.st;

    always_comb begin
        q_d        = q_q;
        buf_we     = 1'b0;
        buf_wdata  = bsh_nx;
        mem_we     = 1'b0;
        unlock_hit = 1'b0;
        q_d.doe    = (kind == CY_RD);

        // consecutive unlock cycles
        if (ev) begin
            if (kind == CY_UNLK) begin
                if (q_q.rcnt == RW'(RST_CYCLES - 1)) begin
                    q_d.rcnt   = '0;
                    unlock_hit = 1'b1;
                end else begin
                    q_d.rcnt = q_q.rcnt + 1'b1;
                end
            end else begin
                q_d.rcnt = '0;
            end
        end

        case (q_q.st)
            ST_PROG: begin
                if (rd_ev)
                    q_d.dio = 1'b0;
                if (q_q.pcnt == CW'(PROG_CYCLES - 1)) begin
                    q_d.st   = ST_COPY;
                    q_d.cidx = '0;
                    q_d.pcnt = '0;
                end else begin
                    q_d.pcnt = q_q.pcnt + 1'b1;
                end
            end
            ST_COPY: begin
                if (rd_ev)
                    q_d.dio = 1'b0;
                mem_we   = q_q.mask[q_q.cidx];
                q_d.cidx = q_q.cidx + 1'b1;
                if (copy_last) begin
                    q_d.st  = ST_IDLE;
                    q_d.wel = 1'b0;
                end
            end
            default: begin
                if (unlock_hit) begin
                    q_d.st   = ST_ADDR;
                    q_d.wel  = 1'b1;
                    q_d.acnt = '0;
                    q_d.bcnt = '0;
                    q_d.mask = '0;
                end else if (ev && kind == CY_WR) begin
                    case (q_q.st)
                        ST_ADDR: begin
                            q_d.ash  = ash_nx;
                            q_d.acnt = q_q.acnt + 1'b1;
                            if (q_q.acnt == 4'd15) begin
                                if ((ash_nx >> ADDR_BITS) != '0) begin
                                    q_d.st  = ST_IDLE;
                                    q_d.wel = 1'b0;
                                end else begin
                                    q_d.st   = ST_DATA;
                                    q_d.base = ash_nx[ADDR_BITS-1:0];
                                    q_d.ptr  = ash_nx[PW-1:0];
                                    q_d.bcnt = '0;
                                end
                            end
                        end
                        ST_DATA: begin
                            q_d.bsh  = bsh_nx;
                            q_d.bcnt = q_q.bcnt + 1'b1;
                            if (q_q.bcnt == 3'd7) begin
                                buf_we              = 1'b1;
                                q_d.mask[q_q.ptr]   = 1'b1;
                                q_d.ptr             = q_q.ptr + 1'b1;
                            end
                        end
                        ST_CMD1: begin
                            if (dio_in) begin
                                q_d.st = ST_CMD2;
                            end else begin
                                q_d.st  = ST_IDLE;
                                q_d.wel = 1'b0;
                            end
                        end
                        ST_CMD2, ST_RDOUT: begin
                            q_d.st  = ST_IDLE;
                            q_d.wel = 1'b0;
                        end
                        default: ;
                    endcase
                end else if (rd_ev) begin
                    q_d.dio = 1'b1;
                    case (q_q.st)
                        ST_DATA: begin
                            if (q_q.bcnt != 3'd0) begin
                                q_d.st  = ST_IDLE;
                                q_d.wel = 1'b0;
                            end else if (q_q.mask == '0) begin
                                q_d.st   = ST_RDOUT;
                                q_d.dio  = rd_bit;
                                q_d.bcnt = 3'd1;
                            end else begin
                                q_d.st = ST_CMD1;
                            end
                        end
                        ST_RDOUT: begin
                            q_d.dio  = rd_bit;
                            q_d.bcnt = q_q.bcnt + 1'b1;
                            if (q_q.bcnt == 3'd7)
                                q_d.ptr = q_q.ptr + 1'b1;
                        end
                        ST_CMD2: begin
                            q_d.st   = ST_PROG;
                            q_d.pcnt = '0;
                        end
                        ST_ADDR, ST_CMD1: begin
                            q_d.st  = ST_IDLE;
                            q_d.wel = 1'b0;
                        end
                        default: ;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q_q <= '0;
        else
            q_q <= q_d;
    end

    assign dio_out = q_q.dio;
    assign dio_oe  = q_q.doe;

endmodule

// File: rtl/spw_checker.sv
module spw_checker
    import spw_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       rd_ev,
    input spw_state_e st_q,
    input logic       wel_q,
    input logic       mem_we,
    input logic       copy_last,
    input logic       dio_out,
    input logic       dio_oe
);

    logic busy;
    assign busy = (st_q == ST_PROG) || (st_q == ST_COPY);

    a_r1_ce_high_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && !busy) |=> ($stable(st_q) && $stable(wel_q)));

    a_r7_busy_read_low: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ev && busy) |=> (!dio_out && dio_oe));

    a_r5_prog_from_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_PROG && !(st_q == ST_CMD2 && rd_ev)) |=> (st_q != ST_PROG));

    a_r2_commit_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CMD2 && rd_ev) |-> wel_q);

    a_r8_latch_clear_after_copy: assert property (@(posedge clk) disable iff (!rst_n)
        copy_last |=> (!wel_q && st_q == ST_IDLE));

    a_r5_mem_write_in_copy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (st_q == ST_COPY));

    a_r10_oe_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
        dio_oe |-> $past(!ce_n));

endmodule

bind spw_page_writer spw_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .rd_ev     (rd_ev),
    .st_q      (st_q),
    .wel_q     (q_q.wel),
    .mem_we    (mem_we),
    .copy_last (copy_last),
    .dio_out   (dio_out),
    .dio_oe    (dio_oe)
);

// File: tb/spw_page_writer_tb.sv
`timescale 1ns/1ps
module spw_page_writer_tb;

    localparam int AB    = 11;
    localparam int PROG  = 50;
    localparam int UNLK  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, dio_in = 1'b0;
    logic dio_out, dio_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        logic  v;
        string tag;
    } exp_t;
    exp_t exq[$];

    logic [7:0] model [1 << AB];

    always #2.5 clk = ~clk;

    spw_page_writer #(
        .ADDR_BITS(AB), .PAGE_BYTES(32), .PROG_CYCLES(PROG), .RST_CYCLES(UNLK)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .dio_in(dio_in), .dio_out(dio_out), .dio_oe(dio_oe)
    );

    // monitor: every new read on the pin pops one expected bit
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && dio_oe && !oe_prev) begin
            checks++;
            if (exq.size() == 0) begin
                errors++;
                $display("FAIL unexpected read: actual %b expected none", dio_out);
            end else begin
                exp_t e;
                e = exq.pop_front();
                if (dio_out !== e.v) begin
                    errors++;
                    $display("FAIL %s: actual %b expected %b", e.tag, dio_out, e.v);
                end
            end
        end
        oe_prev <= dio_oe;
    end

    task automatic bus(input logic c, input logic o, input logic w, input logic d);
        @(negedge clk);
        ce_n = c; oe_n = o; we_n = w; dio_in = d;
        repeat (2) @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_bit(input logic b);
        bus(1'b0, 1'b1, 1'b0, b);
    endtask

    task automatic rd_exp(input logic e, input string tag);
        exp_t x;
        x.v = e; x.tag = tag;
        exq.push_back(x);
        bus(1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic unlock();
        for (int i = 0; i < UNLK; i++) bus(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic send_addr(input logic [15:0] a);
        for (int i = 15; i >= 0; i--) wr_bit(a[i]);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) wr_bit(b[i]);
    endtask

    function automatic int page_idx(input logic [15:0] a, input int k);
        logic [4:0] off;
        off = a[4:0] + 5'(k);
        return int'({a[AB-1:5], off});
    endfunction

    task automatic commit(input string tag);
        rd_exp(1'b1, tag);
        wr_bit(1'b1);
        rd_exp(1'b1, tag);
    endtask

    // full valid page write, model updated
    task automatic page_write(input logic [15:0] a, input logic [7:0] d[$], input string tag);
        unlock();
        send_addr(a);
        foreach (d[i]) begin
            send_byte(d[i]);
            model[page_idx(a, i)] = d[i];
        end
        commit(tag);
    endtask

    task automatic readback(input logic [15:0] a, input int n, input string tag);
        unlock();
        send_addr(a);
        for (int k = 0; k < n; k++)
            for (int b = 7; b >= 0; b--)
                rd_exp(model[page_idx(a, k)][b], tag);
        wr_bit(1'b0);
        rd_exp(1'b1, "R9 status after readback ends");
    endtask

    task automatic wait_prog();
        repeat (PROG + 45) @(negedge clk);
    endtask

    task automatic check_now(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d[$];
        repeat (3) @(negedge clk);
        check_now(dio_oe, 1'b0, "R10 dio_oe after reset");
        check_now(dio_out, 1'b0, "R10 dio_out after reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R7: idle read reports ready
        rd_exp(1'b1, "R7 ready when idle");

        // R5: basic page write, busy status, unlock and writes during busy
        d = '{8'hA5, 8'h3C, 8'h0F, 8'h81};
        page_write(16'h0040, d, "R5 commit reads");
        rd_exp(1'b0, "R7 busy read");
        unlock();
        rd_exp(1'b0, "R7 busy after unlock");
        wr_bit(1'b1);
        rd_exp(1'b0, "R7 busy after write");
        wait_prog();
        rd_exp(1'b1, "R8 ready after programming");
        readback(16'h0040, 4, "R9 readback of committed page");

        // R4: wrap inside page; R8 timing; R1 ce_n high noise
        unlock();
        send_addr(16'h005E);
        send_byte(8'h11); model[page_idx(16'h005E, 0)] = 8'h11;
        bus(1'b1, 1'b0, 1'b0, 1'b1);
        bus(1'b1, 1'b0, 1'b1, 1'b0);
        send_byte(8'h22); model[page_idx(16'h005E, 1)] = 8'h22;
        send_byte(8'h33); model[page_idx(16'h005E, 2)] = 8'h33;
        bus(1'b1, 1'b1, 1'b0, 1'b0);
        commit("R1 commit after ce_n high cycles");
        repeat (PROG - 12) @(negedge clk);
        rd_exp(1'b0, "R8 still programming");
        repeat (PROG) @(negedge clk);
        rd_exp(1'b1, "R8 done after program and copy");
        readback(16'h005E, 3, "R4 wrapped bytes");
        readback(16'h0041, 3, "R5 unloaded bytes untouched");

        // R2: no unlock, latch cleared after completed write
        send_addr(16'h0040);
        send_byte(8'hFF);
        commit("R2 commit without latch");
        wait_prog();
        readback(16'h0040, 1, "R2 no write without latch");

        // R6: partial byte then commit
        unlock();
        send_addr(16'h0040);
        for (int i = 0; i < 12; i++) wr_bit(1'b1);
        commit("R6 partial byte commit");
        send_addr(16'h0040);
        send_byte(8'hEE);
        commit("R6 latch cleared after abort");
        wait_prog();
        readback(16'h0040, 2, "R6 no write after partial");

        // R6: wrong commit bit
        unlock();
        send_addr(16'h0040);
        send_byte(8'h5A);
        rd_exp(1'b1, "R6 bad commit first read");
        wr_bit(1'b0);
        rd_exp(1'b1, "R6 bad commit last read");
        wait_prog();
        readback(16'h0040, 1, "R6 no write after wrong commit bit");

        // R3: out of range address
        unlock();
        send_addr(16'h0840);
        send_byte(8'hC3);
        commit("R3 commit after bad address");
        wait_prog();
        readback(16'h0040, 1, "R3 no write after bad address");

        // R3: read inside address
        unlock();
        for (int i = 0; i < 8; i++) wr_bit(1'b0);
        rd_exp(1'b1, "R3 read inside address");
        send_byte(8'h40);
        send_byte(8'h99);
        commit("R3 commit after broken address");
        wait_prog();
        readback(16'h0040, 1, "R3 no write after broken address");

        // R4: 33 bytes overwrite the first
        d = {};
        for (int i = 0; i < 33; i++) d.push_back(8'(i * 7 + 1));
        page_write(16'h0080, d, "R4 overflow commit");
        wait_prog();
        readback(16'h0080, 2, "R4 first byte overwritten");

        repeat (10) @(negedge clk);
        checks++;
        if (exq.size() != 0) begin
            errors++;
            $display("FAIL R9 pending reads: actual %0d expected 0", exq.size());
        end
        finish_run();
    end

endmodule